// File: doc/BRIEF.md
# UDP/IPv4 Ethernet Header Filter

This block sits on a 512-bit ready/valid stream of raw Ethernet frames that still carry their preamble and start-of-frame byte. It looks at the first beat of each frame, where all 50 header bytes must be present. It compares the sync bytes, the receiver MAC, the EtherType, the IPv4 protocol number, the receiver IP address and the receiver UDP port against values fixed by parameters. Frames that match lose their header beat, and every later beat is passed downstream unchanged. Each forwarded beat carries the payload length, which is derived from the UDP length field.

A frame that fails any comparison is swallowed whole. The block accepts and discards its beats up to and including the one that carries last. It also pulses an error flag for one cycle and advances a saturating error counter.

The header is judged in three steps, one state each:
- `ST_IDLE` checks the link-layer fields.
- `ST_IP` checks the network-layer fields.
- `ST_UDP` checks the port.

The transitions are:
- `ST_IDLE` goes to `ST_IP` on a good link header.
- `ST_IDLE` goes to `ST_DRAIN` on a bad or incomplete header.
- `ST_IP` goes to `ST_UDP` on a match, or to `ST_DRAIN` otherwise.
- `ST_UDP` goes to `ST_DATA` on a match (or to `ST_IDLE` if the header beat is also the last beat), or to `ST_DRAIN` otherwise.
- `ST_DATA` goes to `ST_IDLE` after the accepted last beat.
- `ST_DRAIN` goes to `ST_IDLE` after the accepted last beat.

Top module: `udpf_filter`

## Requirements

Byte k of a beat sits at `data[511-8k -: 8]` and is qualified by `keep[63-k]`. Header byte positions:

| Bytes | Field |
|---|---|
| 0-7 | sync bytes |
| 8-13 | receiver MAC |
| 20-21 | EtherType |
| 31 | IP protocol |
| 38-41 | receiver IP |
| 44-45 | receiver port |
| 46-47 | UDP length |

- R1: A frame start is recognised in idle only when in_valid is high and keep bits 63 down to 14 are all ones. A frame whose first beat lacks any of those bits is discarded up to its last beat with no error counted and no output.
- R2: Bytes 0-7 must equal 55 55 55 55 55 55 55 D5, bytes 8-13 must equal LOCAL_MAC, and bytes 20-21 must equal 0x0800. Any difference rejects the frame.
- R3: Byte 31 must equal 17 and bytes 38-41 must equal LOCAL_IP. Any difference rejects the frame.
- R4: Bytes 44-45 must equal LOCAL_PORT. A difference rejects the frame.
- R5: For a matching frame, the header beat is consumed and not forwarded. Every following beat appears on out_data/out_keep/out_last unchanged. Each forwarded beat carries out_byte_cnt equal to bytes 46-47 minus 8.
- R6: in_ready is low in idle and in the IP stage. In the data state it equals out_ready, and it is high while draining.
- R7: A rejected frame produces no output beat, and all of its beats are accepted until the last.
- R8: Each rejected frame raises err_cnt by one and pulses err_flag high for exactly one cycle, the cycle after the rejecting decision.
- R9: err_cnt stops at its all-ones value and is cleared only by reset.
- R10: During reset, in_ready, out_valid, err_flag and err_cnt are all zero.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | DATA_W | Input beat bytes |
| in_keep | input | DATA_W/8 | Input byte qualifiers |
| in_last | input | 1 | Final beat of frame |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts beat |
| out_data | output | DATA_W | Forwarded payload bytes |
| out_keep | output | DATA_W/8 | Forwarded byte qualifiers |
| out_last | output | 1 | Final forwarded beat |
| out_byte_cnt | output | 16 | Payload byte count from UDP length |
| err_cnt | output | ERR_W | Saturating rejected-frame count |
| err_flag | output | 1 | One-cycle pulse per rejection |

## Verification

The bench builds the filter with ERR_W set to 3, so the counter saturates at 7 after only a handful of rejected frames, and the stop at all ones can be observed within a short run. It keeps DATA_W at 512 and chooses its own local MAC, IP and port values. With these values, each single-field corruption lands in the intended stage: link-layer faults are rejected in idle, and protocol, address and port faults are rejected in the later stages. Random output back-pressure during forwarding and draining exercises the ready coupling.

// File: rtl/udpf_pkg.sv
package udpf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IP,
        ST_UDP,
        ST_DATA,
        ST_DRAIN
    } udpf_state_e;

    // byte offsets from the first byte of a beat
    localparam int OFF_SYNC   = 0;
    localparam int OFF_DMAC   = 8;
    localparam int OFF_ETYPE  = 20;
    localparam int OFF_PROTO  = 31;
    localparam int OFF_DIP    = 38;
    localparam int OFF_DPORT  = 44;
    localparam int OFF_ULEN   = 46;
    localparam int HDR_BYTES  = 50;
    localparam int UDP_HDR_LEN = 8;

    localparam logic [63:0] SYNC_WORD   = 64'h5555_5555_5555_55D5;
    localparam logic [15:0] ETYPE_IPV4  = 16'h0800;
    localparam logic [7:0]  PROTO_UDP   = 8'd17;

endpackage

// File: rtl/udpf_hdr_match.sv
module udpf_hdr_match
    import udpf_pkg::*;
#(
    parameter logic [47:0] LOCAL_MAC  = 48'h02_00_00_00_00_01,
    parameter logic [31:0] LOCAL_IP   = 32'hC0A8_0001,
    parameter logic [15:0] LOCAL_PORT = 16'd4000
) (
    input  logic [63:0] sync_bytes,
    input  logic [47:0] dmac,
    input  logic [15:0] etype,
    input  logic [7:0]  proto,
    input  logic [31:0] dip,
    input  logic [15:0] dport,
    output logic        link_ok,
    output logic        net_ok,
    output logic        port_ok
);

    always_comb begin
        link_ok = (sync_bytes == SYNC_WORD) && (dmac == LOCAL_MAC) && (etype == ETYPE_IPV4);
        net_ok  = (proto == PROTO_UDP) && (dip == LOCAL_IP);
        port_ok = (dport == LOCAL_PORT);
    end

endmodule

// File: rtl/udpf_err_ctr.sv
module udpf_err_ctr #(
    parameter int ERR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [ERR_W-1:0] cnt,
    output logic             flag
);

    localparam logic [ERR_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else begin
            flag <= bump;
            if (bump && (cnt != CNT_MAX))
                cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/udpf_filter.sv
module udpf_filter
    import udpf_pkg::*;
#(
    parameter int          DATA_W     = 512,
    parameter int          ERR_W      = 16,
    parameter logic [47:0] LOCAL_MAC  = 48'h02_00_00_00_00_01,
    parameter logic [31:0] LOCAL_IP   = 32'hC0A8_0001,
    parameter logic [15:0] LOCAL_PORT = 16'd4000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [DATA_W-1:0]   in_data,
    input  logic [DATA_W/8-1:0] in_keep,
    input  logic                in_last,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [DATA_W-1:0]   out_data,
    output logic [DATA_W/8-1:0] out_keep,
    output logic                out_last,
    output logic [15:0]         out_byte_cnt,
    output logic [ERR_W-1:0]    err_cnt,
    output logic                err_flag
);

    localparam int KEEP_W = DATA_W / 8;
    localparam int TOP    = DATA_W - 1;

    udpf_state_e state, state_nx;

    logic [63:0] f_sync;
    logic [47:0] f_dmac;
    logic [15:0] f_etype;
    logic [7:0]  f_proto;
    logic [31:0] f_dip;
    logic [15:0] f_dport;
    logic [15:0] f_ulen;

    logic [7:0]  proto_q;
    logic [31:0] dip_q;
    logic [15:0] dport_q;
    logic [15:0] ulen_q;

    logic hdr_full, link_ok, net_ok, port_ok, reject;

    // live header fields, first byte at the top of the beat
    always_comb begin
        f_sync   = in_data[TOP-8*OFF_SYNC  -: 64];
        f_dmac   = in_data[TOP-8*OFF_DMAC  -: 48];
        f_etype  = in_data[TOP-8*OFF_ETYPE -: 16];
        f_proto  = in_data[TOP-8*OFF_PROTO -: 8];
        f_dip    = in_data[TOP-8*OFF_DIP   -: 32];
        f_dport  = in_data[TOP-8*OFF_DPORT -: 16];
        f_ulen   = in_data[TOP-8*OFF_ULEN  -: 16];
        hdr_full = &in_keep[KEEP_W-1 -: HDR_BYTES];
    end

    udpf_hdr_match #(
        .LOCAL_MAC (LOCAL_MAC),
        .LOCAL_IP  (LOCAL_IP),
        .LOCAL_PORT(LOCAL_PORT)
    ) u_match (
        .sync_bytes(f_sync),
        .dmac      (f_dmac),
        .etype     (f_etype),
        .proto     (proto_q),
        .dip       (dip_q),
        .dport     (dport_q),
        .link_ok   (link_ok),
        .net_ok    (net_ok),
        .port_ok   (port_ok)
    );

    // header field capture while the first beat is waiting in idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            proto_q <= '0;
            dip_q   <= '0;
            dport_q <= '0;
            ulen_q  <= '0;
        end else if (state == ST_IDLE && in_valid) begin
            proto_q <= f_proto;
            dip_q   <= f_dip;
            dport_q <= f_dport;
            ulen_q  <= f_ulen;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // next state and rejection decision
    always_comb begin
        state_nx = state;
        reject   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (in_valid) begin
                    if (!hdr_full) begin
                        state_nx = ST_DRAIN;
                    end else if (link_ok) begin
                        state_nx = ST_IP;
                    end else begin
                        state_nx = ST_DRAIN;
                        reject   = 1'b1;
                    end
                end
            end
            ST_IP: begin
                if (net_ok) begin
                    state_nx = ST_UDP;
                end else begin
                    state_nx = ST_DRAIN;
                    reject   = 1'b1;
                end
            end
            ST_UDP: begin
                if (!port_ok) begin
                    state_nx = ST_DRAIN;
                    reject   = 1'b1;
                end else if (in_valid) begin
                    state_nx = in_last ? ST_IDLE : ST_DATA;
                end
            end
            ST_DATA: begin
                if (in_valid && out_ready && in_last)
                    state_nx = ST_IDLE;
            end
            ST_DRAIN: begin
                if (in_valid && in_last)
                    state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // stream outputs
    always_comb begin
        in_ready     = 1'b0;
        out_valid    = 1'b0;
        unique case (state)
            ST_IDLE, ST_IP: in_ready = 1'b0;
            ST_UDP:         in_ready = port_ok;
            ST_DATA: begin
                in_ready  = out_ready;
                out_valid = in_valid;
            end
            ST_DRAIN:       in_ready = 1'b1;
            default:        in_ready = 1'b0;
        endcase
        out_data     = in_data;
        out_keep     = in_keep;
        out_last     = in_last;
        out_byte_cnt = ulen_q - 16'(UDP_HDR_LEN);
    end

    udpf_err_ctr #(
        .ERR_W(ERR_W)
    ) u_err (
        .clk  (clk),
        .rst_n(rst_n),
        .bump (reject),
        .cnt  (err_cnt),
        .flag (err_flag)
    );

endmodule

// File: rtl/udpf_filter_chk.sv
module udpf_filter_chk #(
    parameter int ERR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_last,
    input logic [15:0]      out_byte_cnt,
    input logic [ERR_W-1:0] err_cnt,
    input logic             err_flag
);

    localparam logic [ERR_W-1:0] CNT_MAX = '1;

    a_r6_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (in_ready == out_ready));

    a_r8_flag_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> !err_flag);

    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> ((err_cnt == $past(err_cnt) + 1'b1) || (err_cnt == CNT_MAX)));

    a_r9_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !err_flag |-> $stable(err_cnt));

    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt == CNT_MAX) |=> (err_cnt == CNT_MAX));

    a_r7_no_out_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> !out_valid);

    a_r5_count_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) ##1 out_valid |-> $stable(out_byte_cnt));

endmodule

bind udpf_filter udpf_filter_chk #(.ERR_W(ERR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_last    (out_last),
    .out_byte_cnt(out_byte_cnt),
    .err_cnt     (err_cnt),
    .err_flag    (err_flag)
);

// File: tb/udpf_filter_test.sv
module udpf_filter_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW   = 512;
    localparam int KW   = DW / 8;
    localparam int EW   = 3;
    localparam int EMAX = (1 << EW) - 1;
    localparam logic [47:0] MY_MAC  = 48'h02_11_22_33_44_55;
    localparam logic [31:0] MY_IP   = 32'hC0A8_0A07;
    localparam logic [15:0] MY_PORT = 16'd5005;
    localparam logic [63:0] SYNC_OK = 64'h5555_5555_5555_55D5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic [KW-1:0] in_keep = '0;
    logic          in_last = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [DW-1:0] out_data;
    logic [KW-1:0] out_keep;
    logic          out_last;
    logic [15:0]   out_byte_cnt;
    logic [EW-1:0] err_cnt;
    logic          err_flag;

    udpf_filter #(
        .DATA_W(DW), .ERR_W(EW),
        .LOCAL_MAC(MY_MAC), .LOCAL_IP(MY_IP), .LOCAL_PORT(MY_PORT)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_keep(in_keep), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_keep(out_keep), .out_last(out_last), .out_byte_cnt(out_byte_cnt),
        .err_cnt(err_cnt), .err_flag(err_flag)
    );

    typedef struct packed {
        logic [DW-1:0] d;
        logic [KW-1:0] k;
        logic          l;
        logic [15:0]   bc;
    } beat_t;

    beat_t exp_q[$];
    int n_chk = 0;
    int n_fail = 0;
    int exp_err = 0;
    int exp_flags = 0;
    int seen_flags = 0;
    bit bp_en = 1'b0;
    bit prev_flag = 1'b0;
    bit done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // downstream ready, changed just after each rising edge
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = bp_en ? lfsr[0] : 1'b1;
    end

    // monitor: pops expected beats and watches the error flag
    always @(negedge clk) begin
        if (rst_n) begin
            if (err_flag) seen_flags++;
            if (err_flag && prev_flag)
                chk(1'b0, "R8", "flag longer than one cycle", 64'(1), 64'(0));
            prev_flag = err_flag;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected output beat", out_data[63:0], 64'(0));
                end else begin
                    beat_t e;
                    e = exp_q.pop_front();
                    chk(out_data == e.d, "R5", "data", out_data[63:0], e.d[63:0]);
                    chk(out_keep == e.k, "R5", "keep", out_keep, e.k);
                    chk(out_last == e.l, "R5", "last", 64'(out_last), 64'(e.l));
                    chk(out_byte_cnt == e.bc, "R5", "byte count", 64'(out_byte_cnt), 64'(e.bc));
                end
            end
        end
    end

    function automatic logic [DW-1:0] mk_hdr(input logic [63:0] sync_w, input logic [47:0] mac,
                                              input logic [15:0] et, input logic [7:0] pr,
                                              input logic [31:0] ip, input logic [15:0] port,
                                              input logic [15:0] ulen);
        logic [DW-1:0] h;
        h = {KW{8'hAA}};
        h[DW-1-8*0  -: 64] = sync_w;
        h[DW-1-8*8  -: 48] = mac;
        h[DW-1-8*14 -: 48] = 48'h0A_0B_0C_0D_0E_0F;
        h[DW-1-8*20 -: 16] = et;
        h[DW-1-8*22 -: 8]  = 8'h45;
        h[DW-1-8*31 -: 8]  = pr;
        h[DW-1-8*38 -: 32] = ip;
        h[DW-1-8*44 -: 16] = port;
        h[DW-1-8*46 -: 16] = ulen;
        return h;
    endfunction

    // driver: presents a frame and records what should come out
    task automatic send_pkt(input logic [DW-1:0] hdr, input logic [KW-1:0] hkeep,
                            input int nbeats, input bit pass, input logic [15:0] ulen,
                            input int seed, input logic [KW-1:0] tail_keep);
        for (int i = 0; i < nbeats; i++) begin
            int j;
            if (i == 0) begin
                in_data = hdr;
                in_keep = hkeep;
            end else begin
                in_data = {16{32'(seed * 256 + i)}};
                in_keep = (i == nbeats - 1) ? tail_keep : '1;
                if (pass) exp_q.push_back('{in_data, in_keep, (i == nbeats - 1), 16'(ulen - 16'd8)});
            end
            in_last  = (i == nbeats - 1);
            in_valid = 1'b1;
            j = 0;
            forever begin
                @(negedge clk);
                if (i == 0 && j == 0)
                    chk(in_ready == 1'b0, "R6", "ready low in idle", 64'(in_ready), 64'(0));
                if (i == 0 && j == 1 && pass)
                    chk(in_ready == 1'b0, "R6", "ready low in IP stage", 64'(in_ready), 64'(0));
                j++;
                if (in_ready) break;
            end
            @(posedge clk);
            #1;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_data  = '0;
        in_keep  = '0;
    endtask

    task automatic reject_pkt(input logic [DW-1:0] hdr, input int nbeats, input string req);
        send_pkt(hdr, '1, nbeats, 1'b0, 16'd40, 99, '1);
        exp_err = (exp_err == EMAX) ? EMAX : exp_err + 1;
        exp_flags++;
        @(negedge clk);
        chk(err_cnt == EW'(exp_err), req, "error count after rejection", 64'(err_cnt), 64'(exp_err));
        chk(exp_q.size() == 0, req, "no output for rejected frame", 64'(exp_q.size()), 64'(0));
        @(posedge clk);
        #1;
    endtask

    task automatic pass_pkt(input int nbeats, input logic [15:0] ulen, input int seed,
                            input logic [KW-1:0] tail_keep);
        send_pkt(mk_hdr(SYNC_OK, MY_MAC, 16'h0800, 8'd17, MY_IP, MY_PORT, ulen), '1,
                 nbeats, 1'b1, ulen, seed, tail_keep);
        @(negedge clk);
        chk(exp_q.size() == 0, "R5", "all payload beats delivered", 64'(exp_q.size()), 64'(0));
        chk(err_cnt == EW'(exp_err), "R5", "no error for match", 64'(err_cnt), 64'(exp_err));
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not finish actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] good;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(in_ready == 1'b0, "R10", "reset in_ready", 64'(in_ready), 64'(0));
        chk(out_valid == 1'b0, "R10", "reset out_valid", 64'(out_valid), 64'(0));
        chk(err_cnt == '0, "R10", "reset err_cnt", 64'(err_cnt), 64'(0));
        chk(err_flag == 1'b0, "R10", "reset err_flag", 64'(err_flag), 64'(0));
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        good = mk_hdr(SYNC_OK, MY_MAC, 16'h0800, 8'd17, MY_IP, MY_PORT, 16'd158);

        // R5 plain forwarding, partial tail
        pass_pkt(3, 16'd158, 1, ~(64'h0) << 42);
        // R6 R5 forwarding under back-pressure
        bp_en = 1'b1;
        pass_pkt(5, 16'd300, 2, '1);
        bp_en = 1'b0;

        // R2 link-layer faults
        reject_pkt(mk_hdr(64'h5555_5555_5555_5555, MY_MAC, 16'h0800, 8'd17, MY_IP, MY_PORT, 16'd40), 2, "R2");
        reject_pkt(mk_hdr(SYNC_OK, MY_MAC ^ 48'h1, 16'h0800, 8'd17, MY_IP, MY_PORT, 16'd40), 2, "R2");
        reject_pkt(mk_hdr(SYNC_OK, MY_MAC, 16'h86DD, 8'd17, MY_IP, MY_PORT, 16'd40), 3, "R2");
        // R3 network-layer faults
        reject_pkt(mk_hdr(SYNC_OK, MY_MAC, 16'h0800, 8'd6, MY_IP, MY_PORT, 16'd40), 2, "R3");
        reject_pkt(mk_hdr(SYNC_OK, MY_MAC, 16'h0800, 8'd17, MY_IP + 32'd1, MY_PORT, 16'd40), 2, "R3");
        // R4 port fault, drained with R7 under back-pressure
        bp_en = 1'b1;
        reject_pkt(mk_hdr(SYNC_OK, MY_MAC, 16'h0800, 8'd17, MY_IP, MY_PORT + 16'd1, 16'd40), 4, "R4");
        bp_en = 1'b0;

        // R1 incomplete header: dropped, no error
        send_pkt(good, ~(64'h1 << 14), 3, 1'b0, 16'd158, 5, '1);
        @(negedge clk);
        chk(err_cnt == EW'(exp_err), "R1", "no error on incomplete header", 64'(err_cnt), 64'(exp_err));
        chk(exp_q.size() == 0, "R1", "no output on incomplete header", 64'(exp_q.size()), 64'(0));
        @(posedge clk);
        #1;

        // recovery after drops
        pass_pkt(2, 16'd72, 7, ~(64'h0) << 8);

        // R9 saturation at the counter top
        reject_pkt(mk_hdr(SYNC_OK, MY_MAC, 16'h0800, 8'd1, MY_IP, MY_PORT, 16'd40), 2, "R9");
        reject_pkt(mk_hdr(SYNC_OK, MY_MAC, 16'h0800, 8'd1, MY_IP, MY_PORT, 16'd40), 2, "R9");
        reject_pkt(mk_hdr(SYNC_OK, MY_MAC, 16'h0800, 8'd1, MY_IP, MY_PORT, 16'd40), 2, "R9");
        chk(err_cnt == EW'(EMAX), "R9", "counter saturated", 64'(err_cnt), 64'(EMAX));

        pass_pkt(4, 16'd200, 9, '1);
        chk(seen_flags == exp_flags, "R8", "flag pulse count", 64'(seen_flags), 64'(exp_flags));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule